// File: doc/BRIEF.md
# Test-Under-Mask Execution Unit

This unit carries out one family of bit-test instructions for an 8-bit CPU built around a register file. A caller gives it an opcode byte, two operand bytes and the current register pointer, then pulses `start`. The unit works out which of six addressing forms is meant. It turns the operand bytes into 12-bit register-file addresses and follows a pointer when the form is indirect. It reads the destination value and the mask through a synchronous read port, ANDs them, and returns an updated flag byte.

The test is non-destructive. The unit has no write port, so neither operand is ever modified. The caller commits `flags_out` when `done` pulses. An opcode outside the family is reported on `illegal`, and in that case the flags come back unchanged.

The register file answers a read one cycle later: `rf_rdata` holds the byte at `rf_raddr` in the cycle after `rf_rd_en` was high.

Top module: `tm_exec_unit`

## Requirements
- R1: Only opcodes 0x72 to 0x77 are legal. For any other opcode, `done` and `illegal` go high together for one cycle, one cycle after `start`. No register-file read is made, and `flags_out` equals the `flags_in` sampled at `start`.
- R2: For 0x72 (register, register) and 0x73 (register, indirect register), the high nibble of `opnd0` is the destination working-register number. The low nibble is the source working-register number, or the number of the pointer register for 0x73.
- R3: For 0x74 and 0x75, `opnd0` is the source register address (0x74) or the address of the source pointer register (0x75). `opnd1` is the destination register address.
- R4: For 0x76 and 0x77, `opnd0` is the destination address (0x76) or the address of the destination pointer register (0x77). `opnd1` is the mask itself and is never read from the register file.
- R5: An 8-bit register address is a working-register reference if its high nibble is 0xE, with the register number in the low nibble. This applies to operand bytes of 0x74 to 0x77 and to pointer values fetched by any indirect form.
- R6: Working register n is at 12-bit address {rp[3:0], rp[7:4], n}. A plain 8-bit address a is at {rp[3:0], a}.
- R7: An indirect form first reads the pointer register. The byte returned is then resolved as an address under R5 and R6.
- R8: Zero flag `flags_out[6]` is 1 exactly when (destination AND mask) is zero.
- R9: Sign flag `flags_out[5]` equals bit 7 of (destination AND mask).
- R10: Overflow flag `flags_out[4]` is 0 after a legal opcode. Carry `[7]`, decimal-adjust `[3]`, half-carry `[2]` and bits `[1:0]` are copied from the `flags_in` sampled at `start`.
- R11: `done` is high for exactly one cycle per instruction. `flags_out` changes only in a cycle where `done` is high. A `start` pulse that arrives while `busy` is high is ignored.
- R12: Reads are issued in this order: pointer, then destination, then source. Counted in cycles from the `start` edge, `done` is high after 4, 6, 4, 6, 3 and 5 cycles for opcodes 0x72 through 0x77 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an instruction (sampled when idle) |
| opcode | input | 8 | Instruction opcode byte |
| opnd0 | input | 8 | First operand byte |
| opnd1 | input | 8 | Second operand byte |
| rp | input | 8 | Register pointer: [7:4] working group, [3:0] page |
| flags_in | input | 8 | Current flag byte |
| busy | output | 1 | Instruction in progress |
| rf_rd_en | output | 1 | Register-file read request |
| rf_raddr | output | 12 | Register-file read address |
| rf_rdata | input | 8 | Read data, valid one cycle after the request |
| flags_out | output | 8 | Updated flag byte: C[7] Z[6] S[5] V[4] D[3] H[2] |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Opcode outside the family, pulsed with done |

## Verification
A wrong decode or a mis-resolved address shows up at the ports within the same instruction. It appears first as a wrong `rf_raddr` in one of the read cycles, and then usually as wrong Z or S flags at `done`. A state machine that skips or repeats a state changes the number of reads and moves `done` away from the 3 to 6 cycle latency for that opcode. Corrupted kept flags appear as a wrong C, D or H bit in the very next `done`. Because the bench fills the register file with address-dependent contents and logs every read address, a fault is flagged in the instruction where it happens.

// File: rtl/tm_exec_unit.sv
module tm_exec_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  opcode,
  input  logic [7:0]  opnd0,
  input  logic [7:0]  opnd1,
  input  logic [7:0]  rp,
  input  logic [7:0]  flags_in,
  output logic        busy,
  output logic        rf_rd_en,
  output logic [11:0] rf_raddr,
  input  logic [7:0]  rf_rdata,
  output logic [7:0]  flags_out,
  output logic        done,
  output logic        illegal
);
  typedef enum logic [2:0] {S_IDLE, S_PTR, S_PTRW, S_DST, S_SRC, S_FIN} st_t;

  st_t         st;
  logic [2:0]  form;
  logic [7:0]  rp_q, imm_q, dst_v;
  logic [4:0]  keep_q;
  logic [11:0] ptr_a, dst_a, src_a;
  logic [7:0]  res;

  function automatic logic [11:0] wreg(input logic [7:0] p, input logic [3:0] n);
    return {p[3:0], p[7:4], n};
  endfunction

  function automatic logic [11:0] resolve(input logic [7:0] p, input logic [7:0] a);
    return (a[7:4] == 4'hE) ? wreg(p, a[3:0]) : {p[3:0], a};
  endfunction

  wire legal  = (opcode[7:3] == 5'b01110) && (opcode[2:1] != 2'b00);
  wire indir  = opcode[0];
  wire imm_f  = (form[2:1] == 2'b11);

  assign busy     = (st != S_IDLE);
  assign rf_rd_en = (st == S_PTR) || (st == S_DST) || (st == S_SRC);
  assign rf_raddr = (st == S_PTR) ? ptr_a : (st == S_SRC) ? src_a : dst_a;
  assign res      = imm_f ? (rf_rdata & imm_q) : (dst_v & rf_rdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      form <= 3'd0;
      rp_q <= 8'h00;
      imm_q <= 8'h00;
      dst_v <= 8'h00;
      keep_q <= 5'd0;
      ptr_a <= 12'h000;
      dst_a <= 12'h000;
      src_a <= 12'h000;
      flags_out <= 8'h00;
      done <= 1'b0;
      illegal <= 1'b0;
    end else begin
      done <= 1'b0;
      illegal <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (!legal) begin
            flags_out <= flags_in;
            done <= 1'b1;
            illegal <= 1'b1;
          end else begin
            form <= opcode[2:0];
            rp_q <= rp;
            imm_q <= opnd1;
            keep_q <= {flags_in[7], flags_in[3:0]};
            case (opcode[2:0])
              3'd2: begin dst_a <= wreg(rp, opnd0[7:4]); src_a <= wreg(rp, opnd0[3:0]); end
              3'd3: begin dst_a <= wreg(rp, opnd0[7:4]); ptr_a <= wreg(rp, opnd0[3:0]); end
              3'd4: begin src_a <= resolve(rp, opnd0); dst_a <= resolve(rp, opnd1); end
              3'd5: begin ptr_a <= resolve(rp, opnd0); dst_a <= resolve(rp, opnd1); end
              3'd6: dst_a <= resolve(rp, opnd0);
              default: ptr_a <= resolve(rp, opnd0);
            endcase
            st <= indir ? S_PTR : S_DST;
          end
        end
        S_PTR:  st <= S_PTRW;
        S_PTRW: begin
          if (form == 3'd7) dst_a <= resolve(rp_q, rf_rdata);
          else              src_a <= resolve(rp_q, rf_rdata);
          st <= S_DST;
        end
        S_DST:  st <= imm_f ? S_FIN : S_SRC;
        S_SRC:  begin dst_v <= rf_rdata; st <= S_FIN; end
        S_FIN:  begin
          flags_out <= {keep_q[4], res == 8'h00, res[7], 1'b0, keep_q[3:0]};
          done <= 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module tm_exec_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       rf_rd_en,
  input logic [7:0] flags_out,
  input logic       done,
  input logic       illegal
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R11
  AST_ILLEGAL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) illegal |-> done); // R1
  AST_OVERFLOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (done && !illegal) |-> !flags_out[4]); // R10
  AST_ZERO_NOT_SIGN: assert property (@(posedge clk) disable iff (!rst_n) (done && !illegal) |-> !(flags_out[6] && flags_out[5])); // R8
  AST_FLAGS_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n) !$stable(flags_out) |-> done); // R11
  AST_NO_READ_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !rf_rd_en); // R12
  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R11
endmodule

bind tm_exec_unit tm_exec_unit_chk chk_i (.*);

// File: tb/tm_exec_unit_tb.sv
`timescale 1ns/1ps
module tm_exec_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] opcode = 8'h00, opnd0 = 8'h00, opnd1 = 8'h00, rp = 8'h00, flags_in = 8'h00;
  logic busy, rf_rd_en, done, illegal;
  logic [11:0] rf_raddr;
  logic [7:0] rf_rdata = 8'h00;
  logic [7:0] flags_out;

  int checks = 0;
  int errors = 0;
  logic [11:0] rlog [4];
  int nrd = 0;

  always #10 clk = ~clk;

  tm_exec_unit dut_i (.*);

  function automatic logic [7:0] mv(input logic [11:0] a);
    logic [7:0] t;
    t = a[7:0] * 8'd29;
    return t ^ {a[11:8], a[11:8]} ^ 8'hC3;
  endfunction

  always @(posedge clk) rf_rdata <= rf_rd_en ? mv(rf_raddr) : 8'h00;

  always @(negedge clk) if (rf_rd_en) begin
    if (nrd < 4) rlog[nrd] <= rf_raddr;
    nrd <= nrd + 1;
  end

  function automatic logic [11:0] wr(input logic [7:0] p, input logic [3:0] n);
    return {p[3:0], p[7:4], n};
  endfunction

  function automatic logic [11:0] ra(input logic [7:0] p, input logic [7:0] a);
    if (a[7:4] == 4'hE) return {p[3:0], p[7:4], a[3:0]};
    return {p[3:0], a};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [7:0] op, input logic [7:0] b0, input logic [7:0] b1,
                        input logic [7:0] r, input logic [7:0] fi, input bit poke);
    logic [11:0] ea [3];
    int en, elat, lat;
    logic [7:0] d, m, res, ef;
    bit ill;
    ea[0] = 0; ea[1] = 0; ea[2] = 0; d = 0; m = 0; ill = 0;
    case (op)
      8'h72: begin ea[0] = wr(r, b0[7:4]); ea[1] = wr(r, b0[3:0]); en = 2; elat = 4; end
      8'h73: begin ea[0] = wr(r, b0[3:0]); ea[1] = wr(r, b0[7:4]); ea[2] = ra(r, mv(ea[0])); en = 3; elat = 6; end
      8'h74: begin ea[0] = ra(r, b1); ea[1] = ra(r, b0); en = 2; elat = 4; end
      8'h75: begin ea[0] = ra(r, b0); ea[1] = ra(r, b1); ea[2] = ra(r, mv(ea[0])); en = 3; elat = 6; end
      8'h76: begin ea[0] = ra(r, b0); en = 1; elat = 3; end
      8'h77: begin ea[0] = ra(r, b0); ea[1] = ra(r, mv(ea[0])); en = 2; elat = 5; end
      default: begin en = 0; elat = 1; ill = 1; end
    endcase
    if (op == 8'h76) begin d = mv(ea[0]); m = b1; end
    else if (op == 8'h77) begin d = mv(ea[1]); m = b1; end
    else if (op == 8'h72 || op == 8'h74) begin d = mv(ea[0]); m = mv(ea[1]); end
    else if (op == 8'h73 || op == 8'h75) begin d = mv(ea[1]); m = mv(ea[2]); end
    res = d & m;
    ef = ill ? fi : {fi[7], res == 8'h00, res[7], 1'b0, fi[3:0]};

    nrd = 0;
    opcode = op; opnd0 = b0; opnd1 = b1; rp = r; flags_in = fi; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin opcode = 8'h01; flags_in = 8'hFF; start = 1'b1; end
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    check(lat == elat, "R12 latency", lat, elat);
    check(illegal == ill, "R1 illegal", illegal, ill);
    check(flags_out == ef, ill ? "R1 flags" : "R8 R9 R10 flags", flags_out, ef);
    check(nrd == en, "R12 read count", nrd, en);
    for (int k = 0; k < 3; k++)
      if (k < en && k < nrd)
        check(rlog[k] == ea[k], "R2 R3 R4 R5 R6 R7 read address", rlog[k], ea[k]);
    @(negedge clk);
    check(!done && !busy, "R11 done pulse", {done, busy}, 2'b00);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rps [4];
    rps[0] = 8'h00; rps[1] = 8'hE3; rps[2] = 8'h5A; rps[3] = 8'h2F;
    repeat (3) @(negedge clk);
    check(!busy && !done && !illegal && !rf_rd_en && flags_out == 8'h00, "R11 reset state",
          {busy, done, illegal, rf_rd_en, flags_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int o = 8'h70; o <= 8'h79; o++)
      for (int ri = 0; ri < 4; ri++)
        for (int i = 0; i < 16; i++)
          for (int j = 0; j < 8; j++) begin
            logic [3:0] hi, lo, jj;
            logic [7:0] b0, b1;
            hi = 4'(i); lo = 4'(i + 5); jj = 4'(j + 8);
            b0 = {hi, lo};
            b1 = {jj, ~4'(j)};
            run_op(8'(o), b0, b1, rps[ri], b0 ^ b1 ^ rps[ri], 1'b0);
          end
    // R11: a start while busy must be ignored
    run_op(8'h72, 8'h3C, 8'h00, 8'h41, 8'hA5, 1'b1);
    run_op(8'h75, 8'hE7, 8'h12, 8'hE3, 8'h5A, 1'b1);
    run_op(8'h76, 8'hE1, 8'h00, 8'h7E, 8'hFF, 1'b1);
    // R1 opcodes far from the legal range
    run_op(8'h00, 8'h11, 8'h22, 8'h33, 8'h9C, 1'b0);
    run_op(8'hFF, 8'h11, 8'h22, 8'h33, 8'h63, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end
endmodule